// File: doc/BRIEF.md
# Compressed Bitmap OR Engine

This block ORs two bitmaps held in a word-aligned run-length code and produces the result in the same code. Each 32-bit word is either a literal that holds 31 raw bitmap bits or a fill that stands for a run of 31-bit groups that are all zeros or all ones. The block reads both operands straight from their compressed form. It does not expand them. A fill can be used up a little at a time while the other operand moves forward.

Each operand arrives on its own valid/ready stream, and the final word of a stream is marked by a last flag. A start pulse begins an operation. The engine keeps one current word per operand and handles each step as fill/fill, fill/literal or literal/literal. Results go through a one-word merge buffer so that neighbouring fills of the same value become a single word. The result leaves on a valid/ready stream. A done pulse closes the operation once the last result word has left the block.

Top module: `cbo_or_engine`

## Requirements
- R1: Word format. Bit 31 set marks a fill: bit 30 is the fill value and bits 29:0 are the run length in 31-bit groups. Bit 31 clear marks a literal whose bits 30:0 are bitmap bits. The engine never outputs a fill with a run length of zero.
- R2: When both current words are fills, the engine outputs a fill whose value is the OR of the two values and whose length is the smaller of the two remaining counts. It subtracts that length from both counts.
- R3: When one word is a fill and the other is a literal, the fill's remaining count drops by one and the literal is used up. A one-fill produces a one-fill of length 1. A zero-fill passes the literal through unchanged.
- R4: When both words are literals, the engine ORs their 31 payload bits. An all-ones result is output as fill 0xC0000001. An all-zeros result is output as fill 0x80000001. Any other result is output as a literal.
- R5: A fill result whose value matches the fill currently held in the merge buffer is added to that fill's count. No new word is written for it.
- R6: A fill count has 30 bits. If a merge would go past 0x3FFFFFFF, the engine outputs a fill with count 0x3FFFFFFF and keeps the remainder as a new pending fill.
- R7: Output handshake. While o_valid is high and o_ready is low, o_data holds steady. No result word is lost or duplicated under back-pressure.
- R8: A new word is accepted on an input only after the current word of that input is used up: a literal after one step, a fill after its count reaches zero. A fill word with a zero count is accepted and skipped.
- R9: An operation ends as soon as the last-flagged word of either stream has been used up. After that point no further input word is accepted, the pending word is flushed, and done pulses for one cycle once the output is empty.
- R10: After reset, done, o_valid, a_ready and b_ready are all low, and nothing is accepted until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation when the engine is idle |
| done | output | 1 | One-cycle pulse when the operation has finished |
| a_valid | input | 1 | Operand A word valid |
| a_ready | output | 1 | Operand A word accepted |
| a_data | input | 32 | Operand A compressed word |
| a_last | input | 1 | Marks the final word of operand A |
| b_valid | input | 1 | Operand B word valid |
| b_ready | output | 1 | Operand B word accepted |
| b_data | input | 32 | Operand B compressed word |
| b_last | input | 1 | Marks the final word of operand B |
| o_valid | output | 1 | Result word valid |
| o_ready | input | 1 | Result word taken by the sink |
| o_data | output | 32 | Result compressed word |

## Verification
Directed vectors each target one step kind with exact expected words. They separate fill/fill minimum splitting, the two fill/literal outcomes, the three literal/literal outcomes, merging across different step kinds, zero-length fill skipping, counter saturation, and an early stop on the shorter stream. Random streams of equal length are then run with input gaps and output back-pressure. Each result is expanded to 31-bit groups and compared with the OR of the expanded operands. This comparison catches lost or shifted groups that a word-by-word check would miss. The random results are also scanned for unmerged neighbouring fills and for zero-length fills.

// File: rtl/cbo_pkg.sv
// Package: shared constants and the sequencing state type of the OR engine.
package cbo_pkg;
    localparam int CBO_WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } cbo_state_e;
endpackage

// File: rtl/cbo_word_decode.sv
// Splits one compressed word into its kind, fill value, run count and literal payload.
// Assumes the kind is in the top bit and the fill value in the next one down.
module cbo_word_decode #(
    parameter int WORD_W = cbo_pkg::CBO_WORD_W,
    localparam int PAY_W = WORD_W - 1,
    localparam int CNT_W = WORD_W - 2
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              is_fill_o,
    output logic              fval_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [PAY_W-1:0]  lit_o
);
    // field extraction
    always_comb begin
        is_fill_o = word_i[WORD_W-1];
        fval_o    = word_i[WORD_W-2];
        cnt_o     = word_i[CNT_W-1:0];
        lit_o     = word_i[PAY_W-1:0];
    end
endmodule

// File: rtl/cbo_operand.sv
// Holds the current word of one operand and tracks how much of a fill remains.
// Accepts a new word only once the held one is used up. Zero-length fills are
// dropped on arrival. Assumes use_i is only raised while a word is held.
module cbo_operand #(
    parameter int WORD_W = cbo_pkg::CBO_WORD_W,
    localparam int PAY_W = WORD_W - 1,
    localparam int CNT_W = WORD_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic              halt_i,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              use_i,
    input  logic [CNT_W-1:0]  dec_i,
    output logic              have_o,
    output logic              fill_o,
    output logic              fval_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [PAY_W-1:0]  lit_o,
    output logic              ended_o
);
    logic             d_fill, d_fval;
    logic [CNT_W-1:0] d_cnt;
    logic [PAY_W-1:0] d_lit;
    logic             have_q, fill_q, fval_q, last_q, ended_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAY_W-1:0] lit_q;

    cbo_word_decode #(.WORD_W(WORD_W)) u_dec (
        .word_i(in_data), .is_fill_o(d_fill), .fval_o(d_fval),
        .cnt_o(d_cnt), .lit_o(d_lit)
    );

    // accept a word only while running, empty, and not stopped
    assign in_ready = run_i && !halt_i && !have_q && !ended_q;

    // load, partial consumption and end-of-stream tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0; fill_q <= 1'b0; fval_q <= 1'b0; last_q <= 1'b0;
            ended_q <= 1'b0; cnt_q <= '0; lit_q <= '0;
        end else if (clear_i) begin
            have_q  <= 1'b0;
            ended_q <= 1'b0;
        end else if (in_ready && in_valid) begin
            fill_q <= d_fill;
            fval_q <= d_fval;
            cnt_q  <= d_cnt;
            lit_q  <= d_lit;
            last_q <= in_last;
            if (d_fill && d_cnt == '0) begin
                have_q  <= 1'b0;
                ended_q <= in_last;
            end else begin
                have_q  <= 1'b1;
            end
        end else if (use_i && have_q) begin
            if (fill_q) begin
                cnt_q <= cnt_q - dec_i;
                if (cnt_q == dec_i) begin
                    have_q  <= 1'b0;
                    ended_q <= last_q;
                end
            end else begin
                have_q  <= 1'b0;
                ended_q <= last_q;
            end
        end
    end

    assign have_o  = have_q;
    assign fill_o  = fill_q;
    assign fval_o  = fval_q;
    assign cnt_o   = cnt_q;
    assign lit_o   = lit_q;
    assign ended_o = ended_q;

    // R8
    fill_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && fill_q) |-> (cnt_q != '0));
    // R2
    dec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && have_q && fill_q) |-> (dec_i != '0 && dec_i <= cnt_q));
    // R8
    use_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_i |-> have_q);
endmodule

// File: rtl/cbo_case_unit.sv
// Combinational step: from the two current words, forms one result item and the
// amount each fill is used by. Covers fill/fill, fill/literal and literal/literal.
// Assumes both inputs hold a word when the result is taken.
module cbo_case_unit #(
    parameter int WORD_W = cbo_pkg::CBO_WORD_W,
    localparam int PAY_W = WORD_W - 1,
    localparam int CNT_W = WORD_W - 2
) (
    input  logic             a_fill, a_fval,
    input  logic [CNT_W-1:0] a_cnt,
    input  logic [PAY_W-1:0] a_lit,
    input  logic             b_fill, b_fval,
    input  logic [CNT_W-1:0] b_cnt,
    input  logic [PAY_W-1:0] b_lit,
    output logic             e_fill, e_fval,
    output logic [CNT_W-1:0] e_cnt,
    output logic [PAY_W-1:0] e_lit,
    output logic [CNT_W-1:0] dec_a, dec_b
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [PAY_W-1:0] lor;
    logic [CNT_W-1:0] run_min;

    assign lor     = a_lit | b_lit;
    assign run_min = (a_cnt < b_cnt) ? a_cnt : b_cnt;

    // choose the handler by the kinds of the two words
    always_comb begin
        e_fill = 1'b0; e_fval = 1'b0; e_cnt = ONE; e_lit = '0;
        dec_a  = '0;   dec_b  = '0;
        if (a_fill && b_fill) begin
            e_fill = 1'b1;
            e_fval = a_fval | b_fval;
            e_cnt  = run_min;
            dec_a  = run_min;
            dec_b  = run_min;
        end else if (a_fill || b_fill) begin
            if (a_fill) dec_a = ONE;
            else        dec_b = ONE;
            if ((a_fill && a_fval) || (b_fill && b_fval)) begin
                e_fill = 1'b1;
                e_fval = 1'b1;
            end else begin
                e_lit = a_fill ? b_lit : a_lit;
            end
        end else if (&lor) begin
            e_fill = 1'b1;
            e_fval = 1'b1;
        end else if (lor == '0) begin
            e_fill = 1'b1;
            e_fval = 1'b0;
        end else begin
            e_lit = lor;
        end
    end
endmodule

// File: rtl/cbo_out_merge.sv
// One-word merge buffer and output register. A fill result joins a pending fill
// of equal value. On counter overflow a full fill is sent and the rest stays
// pending. Any other result pushes the pending word out. Assumes flush_i is only
// raised after the last result has been offered.
module cbo_out_merge #(
    parameter int WORD_W = cbo_pkg::CBO_WORD_W,
    localparam int PAY_W = WORD_W - 1,
    localparam int CNT_W = WORD_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_valid,
    input  logic              e_fill, e_fval,
    input  logic [CNT_W-1:0]  e_cnt,
    input  logic [PAY_W-1:0]  e_lit,
    output logic              e_accept,
    input  logic              flush_i,
    output logic              pend_empty,
    output logic              o_valid,
    output logic [WORD_W-1:0] o_data,
    input  logic              o_ready
);
    localparam logic [CNT_W:0]   CNT_MAX_W = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    logic              p_vld, p_fill, p_fval;
    logic [CNT_W-1:0]  p_cnt;
    logic [PAY_W-1:0]  p_lit;
    logic              out_free, mergeable, ovf, push;
    logic [CNT_W:0]    sum;
    logic [WORD_W-1:0] pend_word, push_word;

    assign out_free  = !o_valid || o_ready;
    assign sum       = {1'b0, p_cnt} + {1'b0, e_cnt};
    assign ovf       = sum > CNT_MAX_W;
    assign mergeable = p_vld && p_fill && e_fill && (p_fval == e_fval);
    assign pend_word = p_fill ? {1'b1, p_fval, p_cnt} : {1'b0, p_lit};
    assign pend_empty = !p_vld;

    // decide whether the result can be taken and what goes to the output
    always_comb begin
        e_accept  = 1'b0;
        push      = 1'b0;
        push_word = pend_word;
        if (e_valid) begin
            if (!p_vld || (mergeable && !ovf)) begin
                e_accept = 1'b1;
            end else if (mergeable) begin
                e_accept  = out_free;
                push      = out_free;
                push_word = {1'b1, p_fval, CNT_MAX};
            end else begin
                e_accept = out_free;
                push     = out_free;
            end
        end else if (flush_i && p_vld) begin
            push = out_free;
        end
    end

    // pending word: load, extend, split on overflow, or drain on flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_vld <= 1'b0; p_fill <= 1'b0; p_fval <= 1'b0;
            p_cnt <= '0;   p_lit  <= '0;
        end else if (e_valid && e_accept) begin
            p_vld <= 1'b1;
            if (!mergeable) begin
                p_fill <= e_fill;
                p_fval <= e_fval;
                p_cnt  <= e_cnt;
                p_lit  <= e_lit;
            end else if (!ovf) begin
                p_cnt <= sum[CNT_W-1:0];
            end else begin
                p_cnt <= CNT_W'(sum - CNT_MAX_W);
            end
        end else if (flush_i && p_vld && out_free) begin
            p_vld <= 1'b0;
        end
    end

    // output register with back-pressure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else if (push) begin
            o_valid <= 1'b1;
            o_data  <= push_word;
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
    // R1
    no_empty_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !(o_data[WORD_W-1] && o_data[CNT_W-1:0] == '0));
    // R6
    pend_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_vld && p_fill) |-> (p_cnt != '0));
endmodule

// File: rtl/cbo_or_engine.sv
// Top of the compressed bitmap OR engine: sequences idle, run and flush; holds
// one operand slot per input stream; feeds the step unit and the merge buffer.
// Assumes both streams are well formed and end with a last-flagged word.
module cbo_or_engine #(
    parameter int WORD_W = cbo_pkg::CBO_WORD_W,
    localparam int PAY_W = WORD_W - 1,
    localparam int CNT_W = WORD_W - 2,
    localparam int N_OPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [WORD_W-1:0] a_data,
    input  logic              a_last,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [WORD_W-1:0] b_data,
    input  logic              b_last,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [WORD_W-1:0] o_data
);
    import cbo_pkg::*;

    cbo_state_e       state_q;
    logic             run, clear, any_end, step, e_valid, e_accept, pend_empty, done_q;
    logic [N_OPS-1:0] in_valid_v, in_last_v, in_ready_v, have_v, fill_v, fval_v, ended_v;
    logic [WORD_W-1:0] in_data_v [N_OPS];
    logic [CNT_W-1:0]  cnt_v     [N_OPS];
    logic [CNT_W-1:0]  dec_v     [N_OPS];
    logic [PAY_W-1:0]  lit_v     [N_OPS];
    logic              e_fill, e_fval;
    logic [CNT_W-1:0]  e_cnt;
    logic [PAY_W-1:0]  e_lit;

    assign run     = (state_q == ST_RUN);
    assign clear   = (state_q == ST_IDLE) && start;
    assign any_end = |ended_v;
    assign e_valid = run && (&have_v);
    assign step    = e_valid && e_accept;

    assign in_valid_v = {b_valid, a_valid};
    assign in_last_v  = {b_last, a_last};
    assign in_data_v[0] = a_data;
    assign in_data_v[1] = b_data;
    assign a_ready = in_ready_v[0];
    assign b_ready = in_ready_v[1];

    // one operand slot per input stream
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        cbo_operand #(.WORD_W(WORD_W)) u_op (
            .clk(clk), .rst_n(rst_n), .clear_i(clear), .run_i(run), .halt_i(any_end),
            .in_valid(in_valid_v[g]), .in_data(in_data_v[g]), .in_last(in_last_v[g]),
            .in_ready(in_ready_v[g]), .use_i(step), .dec_i(dec_v[g]),
            .have_o(have_v[g]), .fill_o(fill_v[g]), .fval_o(fval_v[g]),
            .cnt_o(cnt_v[g]), .lit_o(lit_v[g]), .ended_o(ended_v[g])
        );
    end

    cbo_case_unit #(.WORD_W(WORD_W)) u_case (
        .a_fill(fill_v[0]), .a_fval(fval_v[0]), .a_cnt(cnt_v[0]), .a_lit(lit_v[0]),
        .b_fill(fill_v[1]), .b_fval(fval_v[1]), .b_cnt(cnt_v[1]), .b_lit(lit_v[1]),
        .e_fill(e_fill), .e_fval(e_fval), .e_cnt(e_cnt), .e_lit(e_lit),
        .dec_a(dec_v[0]), .dec_b(dec_v[1])
    );

    cbo_out_merge #(.WORD_W(WORD_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .e_valid(e_valid), .e_fill(e_fill), .e_fval(e_fval),
        .e_cnt(e_cnt), .e_lit(e_lit), .e_accept(e_accept),
        .flush_i(state_q == ST_FLUSH), .pend_empty(pend_empty),
        .o_valid(o_valid), .o_data(o_data), .o_ready(o_ready)
    );

    // operation sequencing: idle -> run -> flush -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_RUN;
                ST_RUN:   if (any_end) state_q <= ST_FLUSH;
                ST_FLUSH: if (pend_empty && !o_valid) begin
                              state_q <= ST_IDLE;
                              done_q  <= 1'b1;
                          end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;

    // R9
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!o_valid && !a_ready && !b_ready));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!a_ready && !b_ready));
endmodule

// File: tb/sim_cbo_or_engine.sv
// Bench for cbo_or_engine: a directed vector table walked by one loop, reset
// checks, then random equal-length streams compared after expansion to groups.
module sim_cbo_or_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [29:0] CMAX = 30'h3FFFFFFF;

    typedef logic [31:0] wq_t[$];
    typedef logic [30:0] gq_t[$];

    // vector table: operand A words, operand B words, expected output, counts
    localparam logic [31:0] VA [0:NV-1][0:3] = '{
        '{32'h80000003, 0, 0, 0},
        '{32'hC0000002, 0, 0, 0},
        '{32'h40000000, 32'h00000000, 32'h2AAAAAAA, 0},
        '{32'h00000000, 32'h80000002, 0, 0},
        '{32'hFFFFFFFF, 32'hC0000005, 0, 0},
        '{32'h80000000, 32'h00000001, 32'h00000002, 0},
        '{32'h00000001, 0, 0, 0},
        '{32'h12340000, 32'h00000100, 0, 0}};
    localparam logic [31:0] VB [0:NV-1][0:3] = '{
        '{32'hC0000002, 32'h00000005, 0, 0},
        '{32'h12345678, 32'h0000000F, 0, 0},
        '{32'h3FFFFFFF, 32'h00000000, 32'h15555555, 0},
        '{32'h00000000, 32'h80000001, 32'h00000011, 0},
        '{32'hBFFFFFFF, 32'h80000005, 0, 0},
        '{32'h00000010, 32'hC0000000, 32'h00000020, 0},
        '{32'h00000002, 32'h00000004, 0, 0},
        '{32'h80000001, 32'hC0000001, 0, 0}};
    localparam logic [31:0] VE [0:NV-1][0:3] = '{
        '{32'hC0000002, 32'h00000005, 0, 0},
        '{32'hC0000002, 0, 0, 0},
        '{32'hC0000001, 32'h80000001, 32'h3FFFFFFF, 0},
        '{32'h80000002, 32'h00000011, 0, 0},
        '{32'hFFFFFFFF, 32'hC0000005, 0, 0},
        '{32'h00000011, 32'h00000022, 0, 0},
        '{32'h00000003, 0, 0, 0},
        '{32'h12340000, 32'hC0000001, 0, 0}};
    localparam int NA [NV] = '{1, 1, 3, 2, 2, 3, 1, 2};
    localparam int NB [NV] = '{2, 2, 3, 3, 2, 3, 2, 2};
    localparam int NE [NV] = '{2, 1, 3, 2, 2, 2, 1, 2};
    localparam int XB [NV] = '{2, 2, 3, 3, 2, 3, 1, 2};
    localparam string VTAG [NV] = '{"R2", "R3", "R4", "R5", "R6", "R8", "R9", "R3"};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0, o_ready = 1'b0;
    logic [31:0] a_data = '0, b_data = '0;
    logic done, a_ready, b_ready, o_valid;
    logic [31:0] o_data;

    int checks = 0, errors = 0;
    int done_cnt = 0, a_taken = 0, b_taken = 0, stall_err = 0;
    bit bp_mode = 1'b0, gap_mode = 1'b0, prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    wq_t sa, sb, so;

    cbo_or_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_last(a_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_last(b_last),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        finish_sim();
    end

    // output sink: drives o_ready, captures accepted words, watches stalls and done
    always @(negedge clk) begin
        if (prev_stall && (!o_valid || o_data != prev_data)) stall_err++;
        o_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
        if (o_valid && o_ready) so.push_back(o_data);
        prev_stall = o_valid && !o_ready;
        prev_data  = o_data;
        if (done) done_cnt++;
    end

    task automatic drive_a();
        int i = 0;
        while (i < sa.size() && done_cnt == 0) begin
            @(negedge clk);
            if (done_cnt != 0) break;
            if (gap_mode && ($urandom % 4 == 0)) a_valid = 1'b0;
            else begin
                a_valid = 1'b1; a_data = sa[i]; a_last = (i == sa.size() - 1);
                if (a_ready) begin i++; a_taken++; end
            end
        end
        if (done_cnt == 0) @(negedge clk);
        a_valid = 1'b0;
    endtask

    task automatic drive_b();
        int i = 0;
        while (i < sb.size() && done_cnt == 0) begin
            @(negedge clk);
            if (done_cnt != 0) break;
            if (gap_mode && ($urandom % 4 == 0)) b_valid = 1'b0;
            else begin
                b_valid = 1'b1; b_data = sb[i]; b_last = (i == sb.size() - 1);
                if (b_ready) begin i++; b_taken++; end
            end
        end
        if (done_cnt == 0) @(negedge clk);
        b_valid = 1'b0;
    endtask

    task automatic run_op();
        so.delete();
        done_cnt = 0; a_taken = 0; b_taken = 0; stall_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        fork
            drive_a();
            drive_b();
        join
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic gq_t expand(wq_t s);
        gq_t g;
        foreach (s[k]) begin
            if (s[k][31]) begin
                for (int c = 0; c < int'(s[k][29:0]); c++) g.push_back({31{s[k][30]}});
            end else g.push_back(s[k][30:0]);
        end
        return g;
    endfunction

    function automatic wq_t gen(int len);
        wq_t s;
        int rem = len;
        while (rem > 0) begin
            int r = $urandom % 10;
            if (r == 0) s.push_back({1'b1, 1'($urandom), 30'd0});
            else if (r < 5) begin
                int c = 1 + $urandom % 5;
                if (c > rem) c = rem;
                s.push_back({1'b1, 1'($urandom), 30'(c)});
                rem -= c;
            end else begin
                logic [30:0] l = 31'($urandom);
                if (r == 5) l = '0;
                if (r == 6) l = '1;
                s.push_back({1'b0, l});
                rem -= 1;
            end
        end
        return s;
    endfunction

    initial begin
        // reset state and no acceptance before start (R10)
        a_valid = 1'b1; b_valid = 1'b1; a_data = 32'h00000001; b_data = 32'h00000001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(o_valid == 1'b0, "R10", "o_valid after reset", o_valid, 0);
        chk(done == 1'b0, "R10", "done after reset", done, 0);
        chk(a_ready == 1'b0, "R10", "a_ready while idle", a_ready, 0);
        chk(b_ready == 1'b0, "R10", "b_ready while idle", b_ready, 0);
        a_valid = 1'b0; b_valid = 1'b0;

        // directed vector table
        for (int v = 0; v < NV; v++) begin
            bit ok;
            sa.delete(); sb.delete();
            for (int k = 0; k < NA[v]; k++) sa.push_back(VA[v][k]);
            for (int k = 0; k < NB[v]; k++) sb.push_back(VB[v][k]);
            run_op();
            ok = (so.size() == NE[v]);
            for (int k = 0; k < NE[v] && k < so.size(); k++) if (so[k] != VE[v][k]) ok = 0;
            chk(ok, VTAG[v], $sformatf("vector %0d output words", v),
                so.size() > 0 ? {32'(so.size()), so[0]} : 0, {32'(NE[v]), VE[v][0]});
            chk(a_taken == NA[v] && b_taken == XB[v], VTAG[v],
                $sformatf("vector %0d words accepted", v), {32'(a_taken), 32'(b_taken)},
                {32'(NA[v]), 32'(XB[v])});
        end

        // directed: vector 4 again under back-pressure keeps the overflow split (R6, R7)
        bp_mode = 1'b1;
        sa.delete(); sb.delete();
        sa.push_back(32'hFFFFFFFF); sa.push_back(32'hC0000005);
        sb.push_back(32'h80000000 | CMAX); sb.push_back(32'h80000005);
        run_op();
        chk(so.size() == 2 && so[0] == 32'hFFFFFFFF && so[1] == 32'hC0000005, "R6",
            "overflow split under back-pressure", so.size() > 0 ? so[0] : 0, 32'hFFFFFFFF);
        chk(stall_err == 0, "R7", "data held while stalled", stall_err, 0);

        // random equal-length streams with gaps and back-pressure
        gap_mode = 1'b1;
        for (int t = 0; t < 6; t++) begin
            gq_t ga, gb, gz;
            bit ok = 1'b1, canon = 1'b1;
            int len = 20 + $urandom % 40;
            sa = gen(len); sb = gen(len);
            run_op();
            ga = expand(sa); gb = expand(sb); gz = expand(so);
            chk(gz.size() == len, "R1", $sformatf("random %0d group count", t), gz.size(), len);
            for (int k = 0; k < len && k < gz.size(); k++) if (gz[k] != (ga[k] | gb[k])) ok = 0;
            chk(ok, "R2", $sformatf("random %0d OR of groups", t), ok, 1);
            foreach (so[k]) begin
                if (so[k][31] && so[k][29:0] == 0) canon = 0;
                if (k > 0 && so[k][31] && so[k-1][31] && so[k][30] == so[k-1][30]
                    && so[k-1][29:0] != CMAX) canon = 0;
            end
            chk(canon, "R5", $sformatf("random %0d fills merged", t), canon, 1);
            chk(a_taken == sa.size() && b_taken == sb.size(), "R8",
                $sformatf("random %0d all words accepted", t), {32'(a_taken), 32'(b_taken)},
                {32'(sa.size()), 32'(sb.size())});
            chk(stall_err == 0, "R7", $sformatf("random %0d stall hold", t), stall_err, 0);
            chk(done_cnt == 1, "R9", $sformatf("random %0d single done pulse", t), done_cnt, 1);
        end
        finish_sim();
    end
endmodule